// File: doc/BRIEF.md
# DMA Controller Control and Status Register File

This block is the control-port front end of a four-channel DMA controller. A host bus selects one of eight control port indices (8 to 15) and writes a byte or reads one back. The writes set the global command byte, the per-channel mode bytes and the channel mask bits. They also start or stop software requests, restart the shared byte pointer, and apply a master reset. Two reads are defined: a status read and a mask read. The status read has a destructive side effect.

The status byte has two halves. The upper nibble holds one request flag per channel. The lower nibble holds one terminal-count flag per channel. Per-channel hold and release lines from devices drive the request flags. A per-channel terminal-count pulse from the transfer engine sets the count flags. The stored bytes leave the block as plain outputs for the channel and transfer logic. A strobe tells the channel register block to reset its low/high byte pointer.

Top module: `dma_ctl_regs`

## Requirements
- R1: After hardware reset, command is 0x00, mask is 4'hF, status is 0x00 and every mode byte is 0x00.
- R2: A write to port 8 loads the command byte only when the data is 0x00 or 0x04. Any other value leaves the command unchanged.
- R3: A write to port 9 selects channel data[1:0]. It sets status bit channel+4 when data[2] is 1 and clears it when data[2] is 0. It always clears status bit channel.
- R4: A write to port 10 sets mask bit data[1:0] when data[2] is 1 and clears it when data[2] is 0. The other mask bits do not change.
- R5: A write to port 11 stores the whole byte as the mode of channel data[1:0]. Channel n appears on mode_bus[8n+7:8n]. The other channels keep their modes. In a mode byte, bit 5 selects decrementing addresses and bits [7:6] select the operating mode.
- R6: A write to port 14 clears all mask bits. A write to port 15 loads the mask from data[3:0].
- R7: A write to port 13 clears status and command and sets all mask bits. The mode bytes do not change.
- R8: ptr_clear is high, in the same cycle, for a write to port 12 or port 13. It is low at all other times.
- R9: While port 8 is read, rd_data shows the status byte. At the end of that cycle, status bits [3:0] clear and bits [7:4] are kept. A terminal-count pulse in the same cycle still sets its bit.
- R10: While port 15 is read, rd_data is {4'b0, mask}. A read of any other port index returns 0x00 and has no side effect.
- R11: dreq_hold[n] sets status bit n+4 and dreq_release[n] clears it. Release wins when both are high. A port 9 write to the same channel in the same cycle overrides both lines.
- R12: tc_pulse[n] sets status bit n. A port 9 write to channel n or a port 13 write in the same cycle overrides the pulse.
- R13: A write to port indices 0 to 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for port_idx |
| rd_en | input | 1 | Read strobe for port_idx |
| port_idx | input | 4 | Control port index (8 to 15 decoded) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from rd_en and port_idx |
| dreq_hold | input | 4 | Per-channel device request assert |
| dreq_release | input | 4 | Per-channel device request drop |
| tc_pulse | input | 4 | Per-channel terminal-count event |
| cmd_q | output | 8 | Command byte |
| mode_bus | output | 32 | Four mode bytes, channel 0 in the low byte |
| mask_q | output | 4 | Channel mask bits |
| status_q | output | 8 | Status: request flags [7:4], count flags [3:0] |
| ptr_clear | output | 1 | Byte pointer clear strobe |

## Verification
Every register in this block appears directly on an output. A wrong decode or a wrong priority therefore shows at the ports one clock after the write that exposes it. A wrong read side effect shows one clock after the status read: either the count flags survive the read, or the request flags are lost. The directed tasks cover these cases. They place competing events in the same cycle (request write against the hold and release lines, terminal count against a status read) so that each priority decision is seen on its own.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int unsigned PORT_W = 4;
  localparam logic [PORT_W-1:0] P_CMD     = 4'h8;
  localparam logic [PORT_W-1:0] P_REQ     = 4'h9;
  localparam logic [PORT_W-1:0] P_SMASK   = 4'hA;
  localparam logic [PORT_W-1:0] P_MODE    = 4'hB;
  localparam logic [PORT_W-1:0] P_CLRPTR  = 4'hC;
  localparam logic [PORT_W-1:0] P_MRESET  = 4'hD;
  localparam logic [PORT_W-1:0] P_CLRMASK = 4'hE;
  localparam logic [PORT_W-1:0] P_WRMASK  = 4'hF;
  localparam int unsigned SET_BIT = 2;
  localparam logic [7:0] CMD_OK_MASK = 8'h04;

  typedef struct packed {
    logic cmd;
    logic req;
    logic smask;
    logic mode;
    logic clrptr;
    logic mreset;
    logic clrmask;
    logic wrmask;
  } wr_strobe_t;
endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
  import dma_ctl_pkg::*;
(
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [PORT_W-1:0] port_idx,
  output wr_strobe_t        ws,
  output logic              rd_status,
  output logic              rd_mask
);
  always_comb begin
    ws         = '0;
    ws.cmd     = wr_en && (port_idx == P_CMD);
    ws.req     = wr_en && (port_idx == P_REQ);
    ws.smask   = wr_en && (port_idx == P_SMASK);
    ws.mode    = wr_en && (port_idx == P_MODE);
    ws.clrptr  = wr_en && (port_idx == P_CLRPTR);
    ws.mreset  = wr_en && (port_idx == P_MRESET);
    ws.clrmask = wr_en && (port_idx == P_CLRMASK);
    ws.wrmask  = wr_en && (port_idx == P_WRMASK);
    rd_status  = rd_en && (port_idx == P_CMD);
    rd_mask    = rd_en && (port_idx == P_WRMASK);
  end

  always_comb begin
    assert ($onehot0(ws)) else $error("AST_ONE_STROBE"); // R13
  end
endmodule

// File: rtl/dma_ctl_mask.sv
module dma_ctl_mask
  import dma_ctl_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wr_strobe_t    ws,
  input  logic [DW-1:0] wr_data,
  output logic [NCH-1:0] mask_q
);
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [CW-1:0] sel;
  assign sel = wr_data[CW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (ws.mreset) begin
      mask_q <= '1;
    end else if (ws.clrmask) begin
      mask_q <= '0;
    end else if (ws.wrmask) begin
      mask_q <= wr_data[NCH-1:0];
    end else if (ws.smask) begin
      mask_q[sel] <= wr_data[SET_BIT];
    end
  end

  AST_MRESET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ws.mreset |=> (mask_q == '1)) else $error("AST_MRESET_MASK"); // R7
  AST_CLRMASK: assert property (@(posedge clk) disable iff (!rst_n)
    ws.clrmask |=> (mask_q == '0)) else $error("AST_CLRMASK"); // R6
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ws.mreset || ws.clrmask || ws.wrmask || ws.smask) |=> $stable(mask_q))
    else $error("AST_MASK_HOLD"); // R4
endmodule

// File: rtl/dma_ctl_status.sv
module dma_ctl_status
  import dma_ctl_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  wr_strobe_t     ws,
  input  logic           rd_status,
  input  logic [DW-1:0]  wr_data,
  input  logic [NCH-1:0] dreq_hold,
  input  logic [NCH-1:0] dreq_release,
  input  logic [NCH-1:0] tc_pulse,
  output logic [2*NCH-1:0] status_q
);
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [CW-1:0] sel;
  assign sel = wr_data[CW-1:0];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic hit;
    assign hit = ws.req && (sel == CW'(ch));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        status_q[ch + NCH] <= 1'b0;
      end else if (ws.mreset) begin
        status_q[ch + NCH] <= 1'b0;
      end else if (hit) begin
        status_q[ch + NCH] <= wr_data[SET_BIT];
      end else if (dreq_release[ch]) begin
        status_q[ch + NCH] <= 1'b0;
      end else if (dreq_hold[ch]) begin
        status_q[ch + NCH] <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        status_q[ch] <= 1'b0;
      end else if (ws.mreset || hit) begin
        status_q[ch] <= 1'b0;
      end else if (tc_pulse[ch]) begin
        status_q[ch] <= 1'b1;
      end else if (rd_status) begin
        status_q[ch] <= 1'b0;
      end
    end

    AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (dreq_release[ch] && !ws.req && !ws.mreset) |=> !status_q[ch + NCH])
      else $error("AST_RELEASE_DROPS"); // R11
    AST_TC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_pulse[ch] && !ws.req && !ws.mreset) |=> status_q[ch])
      else $error("AST_TC_SETS"); // R12
  end

  AST_REQ_CLR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ws.req |=> !status_q[$past(sel)]) else $error("AST_REQ_CLR_LOW"); // R3
  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && (tc_pulse == '0)) |=> (status_q[NCH-1:0] == '0))
    else $error("AST_RD_CLEAR"); // R9
  AST_MRESET_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    ws.mreset |=> (status_q == '0)) else $error("AST_MRESET_STATUS"); // R7
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_ctl_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [PORT_W-1:0] port_idx,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  input  logic [NCH-1:0]    dreq_hold,
  input  logic [NCH-1:0]    dreq_release,
  input  logic [NCH-1:0]    tc_pulse,
  output logic [DW-1:0]     cmd_q,
  output logic [NCH*DW-1:0] mode_bus,
  output logic [NCH-1:0]    mask_q,
  output logic [2*NCH-1:0]  status_q,
  output logic              ptr_clear
);
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1;

  wr_strobe_t ws;
  logic       rd_status;
  logic       rd_mask;
  logic       cmd_legal;

  dma_ctl_decode u_decode (
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .port_idx  (port_idx),
    .ws        (ws),
    .rd_status (rd_status),
    .rd_mask   (rd_mask)
  );

  dma_ctl_mask #(.NCH(NCH), .DW(DW)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .ws      (ws),
    .wr_data (wr_data),
    .mask_q  (mask_q)
  );

  dma_ctl_status #(.NCH(NCH), .DW(DW)) u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .ws           (ws),
    .rd_status    (rd_status),
    .wr_data      (wr_data),
    .dreq_hold    (dreq_hold),
    .dreq_release (dreq_release),
    .tc_pulse     (tc_pulse),
    .status_q     (status_q)
  );

  assign cmd_legal = ((wr_data & ~DW'(CMD_OK_MASK)) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (ws.mreset) begin
      cmd_q <= '0;
    end else if (ws.cmd && cmd_legal) begin
      cmd_q <= wr_data;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_mode
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_bus[ch*DW +: DW] <= '0;
      end else if (ws.mode && (wr_data[CW-1:0] == CW'(ch))) begin
        mode_bus[ch*DW +: DW] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_status) begin
      rd_data = DW'(status_q);
    end else if (rd_mask) begin
      rd_data = DW'(mask_q);
    end
  end

  assign ptr_clear = ws.clrptr || ws.mreset;

  AST_CMD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (ws.cmd && (wr_data != 8'h00) && (wr_data != 8'h04)) |=> $stable(cmd_q))
    else $error("AST_CMD_REJECT"); // R2
  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((cmd_q == 8'h00) || (cmd_q == 8'h04)))
    else $error("AST_CMD_LEGAL"); // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ws.mode |=> $stable(mode_bus)) else $error("AST_MODE_HOLD"); // R5
  AST_QUIET_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_status && !rd_mask) |-> (rd_data == '0))
    else $error("AST_QUIET_READ"); // R10
endmodule

// File: tb/test_dma_ctl_regs.sv
module test_dma_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  port_idx = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [3:0]  dreq_hold = '0;
  logic [3:0]  dreq_release = '0;
  logic [3:0]  tc_pulse = '0;
  logic [7:0]  cmd_q;
  logic [31:0] mode_bus;
  logic [3:0]  mask_q;
  logic [7:0]  status_q;
  logic        ptr_clear;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dma_ctl_regs i_dma_ctl_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .port_idx(port_idx), .wr_data(wr_data), .rd_data(rd_data),
    .dreq_hold(dreq_hold), .dreq_release(dreq_release), .tc_pulse(tc_pulse),
    .cmd_q(cmd_q), .mode_bus(mode_bus), .mask_q(mask_q),
    .status_q(status_q), .ptr_clear(ptr_clear)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // One write cycle, driven between falling edges
  task automatic wr(input logic [3:0] p, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; port_idx = p; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 cmd", cmd_q, 8'h00);
    chk("R1 mask", mask_q, 4'hF);
    chk("R1 status", status_q, 8'h00);
    chk("R1 modes", mode_bus, 32'h0);
    chk("R8 idle", ptr_clear, 1'b0);
  endtask

  task automatic t_command;
    wr(4'h8, 8'h04); chk("R2 accept 04", cmd_q, 8'h04);
    wr(4'h8, 8'h10); chk("R2 reject 10", cmd_q, 8'h04);
    wr(4'h8, 8'h05); chk("R2 reject 05", cmd_q, 8'h04);
    wr(4'h8, 8'h80); chk("R2 reject 80", cmd_q, 8'h04);
    wr(4'h8, 8'h00); chk("R2 accept 00", cmd_q, 8'h00);
  endtask

  task automatic t_request;
    wr(4'h9, 8'h06); chk("R3 set ch2", status_q, 8'h40);
    wr(4'h9, 8'h05); chk("R3 set ch1", status_q, 8'h60);
    wr(4'h9, 8'h02); chk("R3 clr ch2", status_q, 8'h20);
    @(negedge clk); tc_pulse = 4'h3;
    @(negedge clk); tc_pulse = 4'h0;
    chk("R12 tc set", status_q, 8'h23);
    wr(4'h9, 8'h04); chk("R3 clears low bit", status_q, 8'h32);
    wr(4'h9, 8'h01); chk("R3 clr ch1 hi and low", status_q, 8'h10);
    wr(4'h9, 8'h00); chk("R3 clr ch0", status_q, 8'h00);
  endtask

  task automatic t_hold_release;
    @(negedge clk); dreq_hold = 4'b1001;
    @(negedge clk); dreq_hold = 4'b0;
    chk("R11 hold", status_q, 8'h90);
    @(negedge clk); dreq_hold = 4'b1000; dreq_release = 4'b1000;
    @(negedge clk); dreq_hold = 4'b0; dreq_release = 4'b0;
    chk("R11 release wins", status_q, 8'h10);
    @(negedge clk); wr_en = 1'b1; port_idx = 4'h9; wr_data = 8'h04; dreq_release = 4'b0001;
    @(negedge clk); wr_en = 1'b0; dreq_release = 4'b0;
    chk("R11 request write overrides release", status_q, 8'h10);
    @(negedge clk); wr_en = 1'b1; port_idx = 4'h9; wr_data = 8'h00; tc_pulse = 4'b0001;
    @(negedge clk); wr_en = 1'b0; tc_pulse = 4'b0;
    chk("R12 request write overrides tc", status_q, 8'h00);
  endtask

  task automatic t_status_read;
    @(negedge clk); dreq_hold = 4'b0100; tc_pulse = 4'b0101;
    @(negedge clk); dreq_hold = 4'b0; tc_pulse = 4'b0;
    @(negedge clk); rd_en = 1'b1; port_idx = 4'h8;
    #1 chk("R9 read value", rd_data, 8'h45);
    @(negedge clk); rd_en = 1'b0;
    chk("R9 low cleared, high kept", status_q, 8'h40);
    @(negedge clk); tc_pulse = 4'b0010;
    @(negedge clk); rd_en = 1'b1; port_idx = 4'h8; tc_pulse = 4'b1000;
    #1 chk("R9 read value 2", rd_data, 8'h42);
    @(negedge clk); rd_en = 1'b0; tc_pulse = 4'b0;
    chk("R9 tc in read cycle kept", status_q, 8'h48);
    @(negedge clk); rd_en = 1'b1; port_idx = 4'h9;
    #1 chk("R10 other port reads 0", rd_data, 8'h00);
    @(negedge clk); rd_en = 1'b0;
    chk("R10 other read no side effect", status_q, 8'h48);
  endtask

  task automatic t_mask;
    wr(4'hE, 8'hFF); chk("R6 clear all", mask_q, 4'h0);
    wr(4'hA, 8'h06); chk("R4 set bit2", mask_q, 4'h4);
    wr(4'hA, 8'h07); chk("R4 set bit3", mask_q, 4'hC);
    wr(4'hA, 8'h02); chk("R4 clear bit2", mask_q, 4'h8);
    wr(4'hF, 8'hA5); chk("R6 write all", mask_q, 4'h5);
    @(negedge clk); rd_en = 1'b1; port_idx = 4'hF;
    #1 chk("R10 mask read", rd_data, 8'h05);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic t_mode;
    wr(4'hB, 8'h62); chk("R5 ch2 mode", mode_bus, 32'h0062_0000);
    wr(4'hB, 8'h41); chk("R5 ch1 mode", mode_bus, 32'h0062_4100);
    wr(4'hB, 8'hA2); chk("R5 ch2 rewrite", mode_bus, 32'h00A2_4100);
  endtask

  task automatic t_ptr_and_reset;
    @(negedge clk); wr_en = 1'b1; port_idx = 4'hC; wr_data = 8'h00;
    #1 chk("R8 clear pointer", ptr_clear, 1'b1);
    @(negedge clk); wr_en = 1'b0;
    #1 chk("R8 low after", ptr_clear, 1'b0);
    wr(4'h8, 8'h04);
    @(negedge clk); wr_en = 1'b1; port_idx = 4'hD; wr_data = 8'h00;
    #1 chk("R8 master reset strobe", ptr_clear, 1'b1);
    @(negedge clk); wr_en = 1'b0;
    chk("R7 status", status_q, 8'h00);
    chk("R7 cmd", cmd_q, 8'h00);
    chk("R7 mask", mask_q, 4'hF);
    chk("R7 modes kept", mode_bus, 32'h00A2_4100);
  endtask

  task automatic t_low_ports;
    wr(4'hE, 8'h00);
    for (int p = 0; p < 8; p++) wr(4'(p), 8'h04);
    chk("R13 mask", mask_q, 4'h0);
    chk("R13 cmd", cmd_q, 8'h00);
    chk("R13 modes", mode_bus, 32'h00A2_4100);
    chk("R13 status", status_q, 8'h00);
  endtask

  initial begin
    fork
      begin
        #20 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_command();
        t_request();
        t_hold_release();
        t_status_read();
        t_mask();
        t_mode();
        t_ptr_and_reset();
        t_low_ports();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule